// File: doc/BRIEF.md
# TDM Slot Receiver with Channel Remapping

This block takes a serial time-division-multiplexed audio stream on one data pin, clocked by the bit clock and framed by a frame-sync pulse. It turns the stream into four parallel 32-bit channel words. Each slot is 32 bit clocks wide. A frame holds 4 slots (128 clocks) or 8 slots (256 clocks). The block measures the spacing between sync edges to tell which frame size is arriving.

Four control inputs pick the slots that feed the channels:
- **Half select** chooses the lower or upper four slots.
- **Pair swap** exchanges the channel 1/2 pair with the channel 3/4 pair.
- **Bridge mode** feeds each combined pair from a single slot.
- **Odd/even select** chooses which slots bridge mode uses.

A word-length input keeps 16, 24 or 32 bits of each sample. All controls are captured on the sync edge, so a change only takes effect at the next frame. After the last slot a frame needs, all four outputs update together with a one-cycle valid strobe.

The control is a three-state machine:
- **ST_IDLE**: waiting for the first sync after reset.
- **ST_RECV**: capturing slots.
- **ST_DONE**: the needed slots are in, waiting for the next sync.

Its transitions are:
- **T_SYNC**: IDLE→RECV on a sync edge.
- **T_LAST**: RECV→DONE at the end of the last needed slot.
- **T_RESYNC**: RECV or DONE→RECV on a sync edge.

If a sync edge and the last needed slot end on the same clock, T_RESYNC wins, and the finished frame is still published.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset, all channel outputs are zero, `valid_o` and `err_o` are 0, and `frame8_o` is 1 (8-slot frame assumed).
- R2: The MSB of slot 1 is sampled on the clock edge after the edge that first sees `fsync_i` high. Each slot is 32 clocks long and is sent MSB first.
- R3: With bridge mode off, half select 0 and swap 0, slots 1, 2, 3, 4 drive channels 1, 2, 3, 4.
- R4: With half select 1 in an 8-slot frame, slots 5 to 8 are used in place of slots 1 to 4.
- R5: With swap 1 (bridge mode off), the four slots of the selected half drive channels 3, 4, 1, 2 in that order.
- R6: In bridge mode, channels 1 and 2 both carry one slot's word, and channels 3 and 4 both carry the word from the slot two later. The odd/even select picks which slots of the half are used:
  - With odd/even select 0, slots 1 and 3 of the half are used, and with odd/even select 1, slots 2 and 4.
  - Swap 1 gives the earlier of the two slots to channels 3/4 and the later one to channels 1/2.
- R7: `wlen_i` encodings: 00 = 16-bit (the low 16 output bits are zero), 01 = 24-bit (the low 8 bits are zero), 10 or 11 = 32-bit.
- R8: At each sync edge, `frame8_o` is set by the spacing from the previous sync edge. It becomes 0 after a 128-clock gap and 1 after a 256-clock gap, and any other spacing leaves it unchanged.
- R9: If the upper half is selected while `frame8_o` is 0, the frame ends after slot 4. It then publishes all-zero channels with `err_o` = 1. `err_o` returns to 0 at the next publish without the error.
- R10: `valid_o` pulses for exactly one cycle, one clock after the last bit of the highest slot the frame needs. The outputs change only with that pulse and otherwise hold their values.
- R11: Any sync width from 1 clock up to less than the frame length is accepted. Only the rising edge starts a frame.
- R12: Control inputs are captured at the sync edge. Changing them part-way through a frame does not affect that frame's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame-sync pulse |
| sdata_i | input | 1 | Serial audio data, MSB first |
| half_hi_i | input | 1 | 1 selects the upper four slots |
| pair_swap_i | input | 1 | Exchanges the 1/2 and 3/4 channel pairs |
| bridge_i | input | 1 | Bridge mode: one slot per combined channel pair |
| bridge_odd_i | input | 1 | Bridge mode: use the 2nd/4th slots instead of the 1st/3rd |
| wlen_i | input | 2 | Word length (00=16, 01=24, 1x=32) |
| ch1_o | output | 32 | Channel 1 word |
| ch2_o | output | 32 | Channel 2 word |
| ch3_o | output | 32 | Channel 3 word |
| ch4_o | output | 32 | Channel 4 word |
| valid_o | output | 1 | One-cycle strobe when the channel words update |
| err_o | output | 1 | Upper half was requested in a 4-slot frame |
| frame8_o | output | 1 | Measured frame size: 1 = 8 slots, 0 = 4 slots |

## Verification
The assertions check the following on every cycle:
- the valid strobe is never wider than one clock;
- the channel outputs never move without that strobe;
- an error publish always carries zeros;
- slot words and sync edges are never detected on two consecutive clocks.

The bench scenarios are needed for everything else:
- which slot lands on which channel under each combination of half, swap, bridge mode and odd/even select;
- the word-length masking;
- the exact publish cycle;
- frame-size detection from the sync spacing;
- that a mid-frame control change is ignored.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        WLEN_16 = 2'b00,
        WLEN_24 = 2'b01,
        WLEN_32 = 2'b10
    } wlen_e;

    typedef struct packed {
        logic       upper;
        logic       swap;
        logic       bridge;
        logic       odd;
        logic [1:0] wlen;
    } rx_cfg_t;

endpackage

// File: rtl/tdm_sync_detect.sv
module tdm_sync_detect #(
    parameter int SLOT_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync_i,
    output logic frame_start_o,
    output logic frame8_o
);
    localparam int CLKS4 = 4 * SLOT_BITS;
    localparam int CLKS8 = 8 * SLOT_BITS;
    localparam int CW    = $clog2(CLKS8 + 1);

    logic          fsync_q;
    logic [CW-1:0] span_q;

    // A frame starts on the clock where sync is first seen high.
    assign frame_start_o = fsync_i & ~fsync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q  <= 1'b0;
            span_q   <= '0;
            frame8_o <= 1'b1;
        end else begin
            fsync_q <= fsync_i;
            if (frame_start_o) begin
                span_q <= '0;
                if (span_q == CW'(CLKS4 - 1)) begin
                    frame8_o <= 1'b0;
                end else if (span_q == CW'(CLKS8 - 1)) begin
                    frame8_o <= 1'b1;
                end
            end else if (span_q != CW'(CLKS8)) begin
                span_q <= span_q + 1'b1;
            end
        end
    end

    // Two sync starts can never be adjacent: only a rising edge counts.
    assert_start_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

endmodule

// File: rtl/tdm_slot_shift.sv
module tdm_slot_shift #(
    parameter int SLOT_BITS = 32,
    parameter int MAX_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         sdata_i,
    output logic                         word_stb_o,
    output logic [$clog2(MAX_SLOTS)-1:0] slot_o,
    output logic [SLOT_BITS-1:0]         word_o
);
    localparam int BW = $clog2(SLOT_BITS);
    localparam int SW = $clog2(MAX_SLOTS);

    logic [BW-1:0]        bit_q;
    logic [SW-1:0]        slot_q;
    logic                 active_q;
    logic [SLOT_BITS-2:0] shreg_q;

    // The final bit of a slot is taken straight from the pin.
    assign word_stb_o = active_q && (bit_q == BW'(SLOT_BITS - 1));
    assign word_o     = {shreg_q, sdata_i};
    assign slot_o     = slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q    <= '0;
            slot_q   <= '0;
            active_q <= 1'b0;
            shreg_q  <= '0;
        end else if (start_i) begin
            bit_q    <= '0;
            slot_q   <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            shreg_q <= {shreg_q[SLOT_BITS-3:0], sdata_i};
            if (bit_q == BW'(SLOT_BITS - 1)) begin
                bit_q <= '0;
                if (slot_q == SW'(MAX_SLOTS - 1)) begin
                    active_q <= 1'b0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // A completed slot is always followed by at least one more bit clock.
    assert_word_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |=> !word_stb_o);

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_rx_pkg::*;
#(
    parameter int MAX_SLOTS = 8
) (
    input  logic                                     upper_i,
    input  logic                                     swap_i,
    input  logic                                     bridge_i,
    input  logic                                     odd_i,
    input  logic                                     frame8_i,
    output logic [NUM_CH-1:0][$clog2(MAX_SLOTS)-1:0] sel_o,
    output logic [$clog2(MAX_SLOTS)-1:0]             last_o,
    output logic                                     err_o
);
    localparam int SW   = $clog2(MAX_SLOTS);
    localparam int HALF = MAX_SLOTS / 2;

    logic [SW-1:0] base;

    assign base  = upper_i ? SW'(HALF) : '0;
    assign err_o = upper_i & ~frame8_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int PAIR = c / 2;
        always_comb begin
            if (bridge_i) begin
                sel_o[c] = base + SW'(odd_i) + SW'(2 * (PAIR ^ int'(swap_i)));
            end else begin
                sel_o[c] = base + SW'(swap_i ? (c ^ 2) : c);
            end
        end
    end

    // The frame is done once the highest needed slot has arrived.
    always_comb begin
        last_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_o[c] > last_o) begin
                last_o = sel_o[c];
            end
        end
        if (err_o) begin
            last_o = SW'(HALF - 1);
        end
    end

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int MAX_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync_i,
    input  logic                 sdata_i,
    input  logic                 half_hi_i,
    input  logic                 pair_swap_i,
    input  logic                 bridge_i,
    input  logic                 bridge_odd_i,
    input  logic [1:0]           wlen_i,
    output logic [SLOT_BITS-1:0] ch1_o,
    output logic [SLOT_BITS-1:0] ch2_o,
    output logic [SLOT_BITS-1:0] ch3_o,
    output logic [SLOT_BITS-1:0] ch4_o,
    output logic                 valid_o,
    output logic                 err_o,
    output logic                 frame8_o
);
    localparam int SW = $clog2(MAX_SLOTS);

    rx_state_e                          state_q, state_d;
    rx_cfg_t                            cfg_q;
    logic                               start;
    logic                               word_stb;
    logic [SW-1:0]                      slot;
    logic [SLOT_BITS-1:0]               word;
    logic [NUM_CH-1:0][SW-1:0]          sel;
    logic [SW-1:0]                      last_slot;
    logic                               map_err;
    logic                               done;
    logic                               pub_q;
    logic                               pub_err_q;
    logic [NUM_CH-1:0][SLOT_BITS-1:0]   stage_q;
    logic [NUM_CH-1:0][SLOT_BITS-1:0]   out_q;

    tdm_sync_detect #(.SLOT_BITS(SLOT_BITS)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .fsync_i       (fsync_i),
        .frame_start_o (start),
        .frame8_o      (frame8_o)
    );

    tdm_slot_shift #(.SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sdata_i    (sdata_i),
        .word_stb_o (word_stb),
        .slot_o     (slot),
        .word_o     (word)
    );

    tdm_slot_map #(.MAX_SLOTS(MAX_SLOTS)) u_map (
        .upper_i  (cfg_q.upper),
        .swap_i   (cfg_q.swap),
        .bridge_i (cfg_q.bridge),
        .odd_i    (cfg_q.odd),
        .frame8_i (frame8_o),
        .sel_o    (sel),
        .last_o   (last_slot),
        .err_o    (map_err)
    );

    function automatic logic [SLOT_BITS-1:0] trim_word(
        input logic [SLOT_BITS-1:0] w,
        input logic [1:0]           len
    );
        logic [SLOT_BITS-1:0] keep;
        unique case (len)
            WLEN_16: keep = {SLOT_BITS{1'b1}} << (SLOT_BITS - 16);
            WLEN_24: keep = {SLOT_BITS{1'b1}} << (SLOT_BITS - 24);
            default: keep = {SLOT_BITS{1'b1}};
        endcase
        return w & keep;
    endfunction

    assign done = (state_q == ST_RECV) && word_stb && (slot == last_slot);

    // Next-state logic: T_SYNC, T_LAST, T_RESYNC.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RECV;
            ST_RECV: begin
                if (start)     state_d = ST_RECV;
                else if (done) state_d = ST_DONE;
            end
            ST_DONE: if (start) state_d = ST_RECV;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration capture at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{upper: 1'b0, swap: 1'b0, bridge: 1'b0, odd: 1'b0, wlen: WLEN_32};
        end else if (start) begin
            cfg_q <= '{upper: half_hi_i, swap: pair_swap_i, bridge: bridge_i,
                       odd: bridge_odd_i, wlen: wlen_i};
        end
    end

    // Per-channel staging of the selected slot words.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[c] <= '0;
            end else if (state_q == ST_RECV && word_stb && slot == sel[c]) begin
                stage_q[c] <= trim_word(word, cfg_q.wlen);
            end
        end
    end

    // Output process: publish one clock after the last needed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_q     <= 1'b0;
            pub_err_q <= 1'b0;
            valid_o   <= 1'b0;
            err_o     <= 1'b0;
            out_q     <= '0;
        end else begin
            pub_q   <= done;
            valid_o <= pub_q;
            if (done) begin
                pub_err_q <= map_err;
            end
            if (pub_q) begin
                err_o <= pub_err_q;
                out_q <= pub_err_q ? '0 : stage_q;
            end
        end
    end

    assign ch1_o = out_q[0];
    assign ch2_o = out_q[1];
    assign ch3_o = out_q[2];
    assign ch4_o = out_q[3];

    assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(out_q));

    assert_valid_after_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> state_q != ST_IDLE);

    assert_err_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o) |-> (out_q == '0));

endmodule

// File: tb/tdm_slot_rx_tb_top.sv
module tdm_slot_rx_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0][31:0] ch;
        logic             err;
        int               cyc;
        string            tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync_i = 1'b0, sdata_i = 1'b0;
    logic        half_hi_i = 1'b0, pair_swap_i = 1'b0, bridge_i = 1'b0, bridge_odd_i = 1'b0;
    logic [1:0]  wlen_i = 2'b10;
    logic [31:0] ch1_o, ch2_o, ch3_o, ch4_o;
    logic        valid_o, err_o, frame8_o;

    int   checks = 0, errors = 0, cycle = 0, fid = 0, prev_len = 0;
    logic exp_frame8 = 1'b1, prev_lsb = 1'b0, done = 1'b0;
    logic [3:0][31:0] last_pub = '0;
    exp_t sbq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    tdm_slot_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .sdata_i(sdata_i),
        .half_hi_i(half_hi_i), .pair_swap_i(pair_swap_i), .bridge_i(bridge_i),
        .bridge_odd_i(bridge_odd_i), .wlen_i(wlen_i),
        .ch1_o(ch1_o), .ch2_o(ch2_o), .ch3_o(ch3_o), .ch4_o(ch4_o),
        .valid_o(valid_o), .err_o(err_o), .frame8_o(frame8_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_val(input int f, input int s);
        return 32'h9E3779B9 * (f * 8 + s + 1);
    endfunction

    // Reference slot choice, written from the requirement tables.
    function automatic int ref_slot(input int c, input bit up, input bit sw, input bit br, input bit od);
        int base, first, second;
        base = up ? 4 : 0;
        if (!br) begin
            if (!sw) return base + c;
            case (c)
                0: return base + 2;
                1: return base + 3;
                2: return base + 0;
                default: return base + 1;
            endcase
        end
        first  = base + (od ? 1 : 0);
        second = first + 2;
        if (c < 2) return sw ? second : first;
        return sw ? first : second;
    endfunction

    function automatic logic [31:0] ref_trim(input logic [31:0] w, input logic [1:0] wl);
        if (wl == 2'b00) return {w[31:16], 16'h0};
        if (wl == 2'b01) return {w[31:8], 8'h0};
        return w;
    endfunction

    // Driver: pushes expected result, then drives one frame.
    task automatic send_frame(input int n, input int sw_w, input bit up, input bit sw,
                              input bit br, input bit od, input logic [1:0] wl,
                              input string tag, input int chg_at);
        logic [31:0] vals [8];
        exp_t e;
        int last;
        for (int s = 0; s < 8; s++) vals[s] = slot_val(fid, s);
        if (prev_len == 128) exp_frame8 = 1'b0;
        else if (prev_len == 256) exp_frame8 = 1'b1;
        e.err = up && !exp_frame8;
        e.tag = tag;
        last = 0;
        for (int c = 0; c < 4; c++) begin
            int rs;
            rs = ref_slot(c, up, sw, br, od);
            if (rs > last) last = rs;
            e.ch[c] = e.err ? 32'h0 : ref_trim(vals[rs], wl);
        end
        if (e.err) last = 3;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                e.cyc = cycle + 1 + 32 * (last + 1) + 1;
                sbq.push_back(e);
                half_hi_i = up; pair_swap_i = sw; bridge_i = br;
                bridge_odd_i = od; wlen_i = wl;
                sdata_i = prev_lsb;
            end else begin
                sdata_i = vals[(i - 1) / 32][31 - ((i - 1) % 32)];
            end
            fsync_i = (i < sw_w);
            if (i == chg_at) begin
                half_hi_i = ~up; pair_swap_i = ~sw; wlen_i = 2'b00;
            end
            if (i == 5) begin
                chk({"R8 frame size ", tag}, 32'(frame8_o), 32'(exp_frame8));
                chk({"R10 hold ch1 ", tag}, ch1_o, last_pub[0]);
                chk({"R10 hold ch4 ", tag}, ch4_o, last_pub[3]);
            end
        end
        prev_lsb = vals[n / 32 - 1][0];
        prev_len = n;
        fid++;
    endtask

    // Monitor: compares each publish against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sbq.size() == 0) begin
                chk("R10 unexpected valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({"R10 publish cycle ", e.tag}, 32'(cycle), 32'(e.cyc));
                chk({"ch1 ", e.tag}, ch1_o, e.ch[0]);
                chk({"ch2 ", e.tag}, ch2_o, e.ch[1]);
                chk({"ch3 ", e.tag}, ch3_o, e.ch[2]);
                chk({"ch4 ", e.tag}, ch4_o, e.ch[3]);
                chk({"R9 err flag ", e.tag}, 32'(err_o), 32'(e.err));
                last_pub = e.ch;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(valid_o), 32'd0);
        chk("R1 err", 32'(err_o), 32'd0);
        chk("R1 frame8", 32'(frame8_o), 32'd1);
        chk("R1 ch1", ch1_o, 32'h0);
        chk("R1 ch3", ch3_o, 32'h0);
        send_frame(256, 1, 0, 0, 0, 0, 2'b10, "R2 R3 lower in order", -1);
        send_frame(256, 2, 1, 0, 0, 0, 2'b11, "R4 upper half", -1);
        send_frame(256, 2, 0, 1, 0, 0, 2'b00, "R5 R7 swap 16-bit", -1);
        send_frame(256, 5, 1, 1, 0, 0, 2'b01, "R4 R5 R7 R11 upper swap 24-bit", -1);
        send_frame(256, 2, 0, 0, 1, 0, 2'b10, "R6 bridge first/third", -1);
        send_frame(256, 3, 1, 1, 1, 1, 2'b10, "R6 bridge upper odd swap", -1);
        send_frame(128, 2, 0, 0, 0, 0, 2'b10, "R8 R11 4-slot frame", -1);
        send_frame(128, 2, 1, 0, 0, 0, 2'b10, "R9 upper in 4-slot", -1);
        send_frame(128, 100, 0, 0, 1, 1, 2'b10, "R9 R11 error cleared", -1);
        send_frame(256, 2, 0, 1, 0, 0, 2'b10, "R12 mid-frame change", 10);
        @(negedge clk);
        fsync_i = 1'b0; sdata_i = prev_lsb;
        repeat (40) @(negedge clk);
        sdata_i = 1'b0;
        chk("R10 all publishes seen", 32'(sbq.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule